// File: doc/BRIEF.md
# Resynchronizable Clock Divider Channel

This block divides its input clock by an integer ratio and can be brought back into a known phase on demand. The active-low sync pin or a register-held soft-sync bit freezes the output low. When both sources let go, the channel waits a fixed number of input-clock cycles and then restarts with a rising edge. Several channels share one sync pin and one clock. When they are released together, every channel with the same ratio starts in phase.

The sync pin is asynchronous. It passes through a flop synchronizer and then a restart delay counter. An optional pre-divider stage sits in front of the channel. It is modelled as one extra retiming flop in the pin path. The soft-sync bit is written into a shadow register. It reaches the active register only when a separate update bit is written as 1. That update flag clears itself on the cycle after it commits. A release that falls close to a clock edge can land one cycle earlier or later. The fixed pipeline keeps the restart inside a 14-to-15-cycle window, plus one cycle when the pre-stage is fitted.

Top module: `resync_div_channel`

## Requirements
- R1: While reset is asserted, and until the first restart after it, `clk_out` is low. After reset the soft-sync shadow and active bits are 0.
- R2: While the pin is held low, `clk_out` is static low from the third rising edge after the pin is sampled low onward. With the pre-stage fitted this is the fourth edge.
- R3: After the pin rises, the first rising edge of `clk_out` occurs on clock edge 14 (15 with `PRE_STAGE`=1). Edge 1 is the first rising edge that samples the pin high.
- R4: Each restart begins with a rising edge. The output period is N input cycles. The output is high for N - floor(N/2) cycles and low for floor(N/2) cycles, so an even N gives a 50% duty cycle.
- R5: Ratio values 0 and 1 on `div_ratio` are treated as 2.
- R6: `div_ratio` is sampled only while the channel is held or counting down to restart. A change while the output runs takes effect only after the next sync.
- R7: A write with `cfg_addr`=0 stores `cfg_wdata` as the shadow soft-sync value. This write has no effect on `clk_out` until an update is committed.
- R8: A write with `cfg_addr`=1 and `cfg_wdata`=1 sets an update flag. On the next edge the flag copies the shadow bit into the active bit and then clears itself. After a soft release is committed, the first rising edge of `clk_out` comes 13 edges after the edge that accepts the update write.
- R9: The channel is released only when the synchronized pin is high and the active soft-sync bit is 0. Either source alone holds the output low.
- R10: A write with `cfg_addr`=1 and `cfg_wdata`=0 commits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Channel divider input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Asynchronous active-low sync request pin |
| div_ratio | input | RATIO_W | Integer divide ratio N |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0: soft-sync shadow, 1: update commit |
| cfg_wdata | input | 1 | Register write data bit |
| clk_out | output | 1 | Divided output clock |

## Verification
A restart counter that is off by one shows up on the first restart. The first `clk_out` rise moves away from edge 14, so a single release exposes it. A phase counter that wraps at the wrong point, or a wrong high-length function, skews the high and low run lengths within the first output period. This is clearest for odd ratios and for the clamped values. A soft-sync path that skips the commit stage makes the output stop or start right after a shadow write, and this shows within three cycles. A ratio register that keeps following the input distorts the very next period after a change in the middle of a run.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  // Ratios below two cannot be produced by a registered output; clamp them.
  function automatic int unsigned clamp_ratio(input int unsigned n);
    return (n < 2) ? 2 : n;
  endfunction

  // Number of high cycles per output period (ceiling half).
  function automatic int unsigned high_len(input int unsigned n);
    return n - (n / 2);
  endfunction

  // Countdown length after the two-flop synchronizer for a given total
  // latency; the optional pre-stage adds its own flop and is not subtracted.
  function automatic int unsigned restart_delay(input int unsigned base_lat);
    return base_lat - 2;
  endfunction

endpackage

// File: rtl/rdc_sync_chain.sv
module rdc_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_in or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk_in or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/rdc_cfg_regs.sv
module rdc_cfg_regs (
  input  logic clk_in,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_addr,
  input  logic cfg_wdata,
  output logic soft_active,
  output logic upd_pending
);
  logic soft_shadow;
  logic wr_shadow;
  logic wr_commit;

  assign wr_shadow = cfg_we && !cfg_addr;
  assign wr_commit = cfg_we && cfg_addr && cfg_wdata;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      soft_shadow <= 1'b0;
      soft_active <= 1'b0;
      upd_pending <= 1'b0;
    end else begin
      if (wr_shadow) soft_shadow <= cfg_wdata;
      if (upd_pending) soft_active <= soft_shadow;
      upd_pending <= wr_commit;
    end
  end

  // R8: the update flag never lingers past its commit cycle
  assert_update_selfclear_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
    (upd_pending && !wr_commit) |=> !upd_pending);

  // R7: the active bit moves only on a commit
  assert_soft_commit_only_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    !upd_pending |=> $stable(soft_active));

  // R10: a commit write with data 0 raises no flag
  assert_no_commit_on_zero_R10: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cfg_we && cfg_addr && !cfg_wdata) |=> !upd_pending);
endmodule

// File: rtl/rdc_restart_timer.sv
module rdc_restart_timer
  import rdc_pkg::*;
#(
  parameter int BASE_LAT = 14
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic release_ok,
  input  logic running,
  output logic restart
);
  localparam int DLY = restart_delay(BASE_LAT);
  localparam int DCW = $clog2(DLY + 1);
  localparam logic [DCW-1:0] LAST = DCW'(DLY - 1);

  logic [DCW-1:0] dcnt;

  assign restart = release_ok && !running && (dcnt == LAST);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)                             dcnt <= '0;
    else if (!release_ok)                   dcnt <= '0;
    else if (!running && !restart)          dcnt <= dcnt + 1'b1;
  end

  // R3: a restart is a single-cycle event
  assert_restart_single_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
    restart |=> !restart);

  // R9: the countdown never advances while held
  assert_count_cleared_R9: assert property (@(posedge clk_in) disable iff (!rst_n)
    !release_ok |=> (dcnt == '0));
endmodule

// File: rtl/rdc_phase_gen.sv
module rdc_phase_gen
  import rdc_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               release_ok,
  input  logic               restart,
  input  logic [RATIO_W-1:0] div_ratio,
  output logic               running,
  output logic               clk_out
);
  logic [RATIO_W-1:0] n_q;
  logic [RATIO_W-1:0] n_eff;
  logic [RATIO_W-1:0] hi_len;
  logic [RATIO_W-1:0] ph;
  logic [RATIO_W-1:0] ph_nx;

  assign n_eff  = RATIO_W'(clamp_ratio(32'(n_q)));
  assign hi_len = RATIO_W'(high_len(32'(n_eff)));
  assign ph_nx  = (ph == n_eff - 1'b1) ? '0 : ph + 1'b1;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)        n_q <= '0;
    else if (!running) n_q <= div_ratio;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ph      <= '0;
      clk_out <= 1'b0;
    end else if (!release_ok) begin
      running <= 1'b0;
      ph      <= '0;
      clk_out <= 1'b0;
    end else if (restart) begin
      running <= 1'b1;
      ph      <= '0;
      clk_out <= 1'b1;
    end else if (running) begin
      ph      <= ph_nx;
      clk_out <= (ph_nx < hi_len);
    end
  end

  // R4: every restart opens with a high phase
  assert_first_edge_rises_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (restart && release_ok) |=> clk_out);

  // R4: the phase stays inside one period
  assert_phase_in_range_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
    running |-> (ph < n_eff));

  // R6: the ratio is frozen while the output runs
  assert_ratio_frozen_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (running && release_ok) |=> $stable(n_q));
endmodule

// File: rtl/resync_div_channel.sv
module resync_div_channel #(
  parameter int RATIO_W   = 8,
  parameter int BASE_LAT  = 14,
  parameter int PRE_STAGE = 0
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic [RATIO_W-1:0] div_ratio,
  input  logic               cfg_we,
  input  logic               cfg_addr,
  input  logic               cfg_wdata,
  output logic               clk_out
);
  localparam int SYNC_STAGES = 2 + PRE_STAGE;

  logic pin_sync;
  logic soft_active;
  logic upd_pending;
  logic release_ok;
  logic running;
  logic restart;

  rdc_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .pin_n   (sync_n),
    .pin_sync(pin_sync)
  );

  rdc_cfg_regs u_cfg (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .soft_active(soft_active),
    .upd_pending(upd_pending)
  );

  // Either hold source keeps the channel frozen.
  assign release_ok = pin_sync && !soft_active;

  rdc_restart_timer #(.BASE_LAT(BASE_LAT)) u_timer (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .release_ok(release_ok),
    .running   (running),
    .restart   (restart)
  );

  rdc_phase_gen #(.RATIO_W(RATIO_W)) u_phase (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .release_ok(release_ok),
    .restart   (restart),
    .div_ratio (div_ratio),
    .running   (running),
    .clk_out   (clk_out)
  );

  // R2 / R9: a held channel shows a static low output
  assert_hold_static_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
    !release_ok |=> !clk_out);

  // R1: no output activity before the first restart
  assert_idle_until_restart_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!running && !restart) |=> !clk_out);
endmodule

// File: tb/tb_resync_div_channel.sv
`timescale 1ns/1ps
module tb_resync_div_channel;
  logic       clk_in = 1'b0;
  logic       rst_n;
  logic       sync_n;
  logic [7:0] div_ratio;
  logic       cfg_we;
  logic       cfg_addr;
  logic       cfg_wdata;
  logic       clk_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk_in = ~clk_in;

  resync_div_channel dut (
    .clk_in(clk_in), .rst_n(rst_n), .sync_n(sync_n), .div_ratio(div_ratio),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .clk_out(clk_out)
  );

  // ratio, expected high cycles, expected low cycles
  localparam int VEC [8][3] = '{
    '{4, 2, 2}, '{2, 1, 1}, '{3, 2, 1}, '{1, 1, 1},
    '{0, 1, 1}, '{7, 4, 3}, '{8, 4, 4}, '{5, 3, 2}
  };
  localparam int PIN_LAT  = 14;
  localparam int SOFT_LAT = 13;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold_low_and_check(input int cycles, input string req);
    int highs = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_in);
      if (k >= 3 && clk_out) highs++;
    end
    check(highs == 0, req, highs, 0);
  endtask

  task automatic wait_rise(output int lat);
    lat = 0;
    while (!clk_out && lat < 300) begin
      @(negedge clk_in);
      lat++;
    end
  endtask

  // Called at the negedge where clk_out is first seen high.
  task automatic measure_period(output int hi, output int lo);
    hi = 1; lo = 0;
    forever begin
      @(negedge clk_in);
      if (clk_out && hi < 300) hi++; else break;
    end
    lo = 1;
    forever begin
      @(negedge clk_in);
      if (!clk_out && lo < 300) lo++; else break;
    end
  endtask

  task automatic cfg_write(input logic a, input logic d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk_in);
    cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = 1'b0;
  endtask

  task automatic count_toggles(input int cycles, output int tg);
    logic prev;
    tg = 0;
    prev = clk_out;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_in);
      if (clk_out != prev) tg++;
      prev = clk_out;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_in);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, hi, lo, tg;
    rst_n = 1'b0; sync_n = 1'b0; div_ratio = 8'd4;
    cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = 1'b0;
    repeat (4) @(negedge clk_in);
    check(clk_out == 1'b0, "R1 reset output", clk_out, 0);
    rst_n = 1'b1;
    hold_low_and_check(8, "R2 held after reset");

    // vector table: hold, set ratio, release, measure latency and shape
    for (int i = 0; i < 8; i++) begin
      sync_n = 1'b0;
      div_ratio = 8'(VEC[i][0]);
      hold_low_and_check(8, "R2 held output static");
      sync_n = 1'b1;
      wait_rise(lat);
      check(lat == PIN_LAT, "R3 pin release latency", lat, PIN_LAT);
      measure_period(hi, lo);
      check(hi == VEC[i][1], "R4 R5 high run", hi, VEC[i][1]);
      check(lo == VEC[i][2], "R4 R5 low run", lo, VEC[i][2]);
    end

    // R6: ratio change during a run is ignored until the next sync
    sync_n = 1'b0; div_ratio = 8'd4;
    repeat (6) @(negedge clk_in);
    sync_n = 1'b1;
    wait_rise(lat);
    div_ratio = 8'd6;
    measure_period(hi, lo);
    check(hi == 2 && lo == 2, "R6 ratio frozen while running", hi * 10 + lo, 22);
    sync_n = 1'b0;
    repeat (6) @(negedge clk_in);
    sync_n = 1'b1;
    wait_rise(lat);
    measure_period(hi, lo);
    check(hi == 3 && lo == 3, "R6 new ratio after sync", hi * 10 + lo, 33);

    // R7: shadow write alone leaves the output running
    cfg_write(1'b0, 1'b1);
    count_toggles(20, tg);
    check(tg > 0, "R7 shadow write no effect", tg, 1);

    // R10: commit write with data 0 does nothing
    cfg_write(1'b1, 1'b0);
    count_toggles(20, tg);
    check(tg > 0, "R10 zero commit ignored", tg, 1);

    // R8 / R9: real commit holds the output although the pin is high
    cfg_write(1'b1, 1'b1);
    hold_low_and_check(20, "R9 soft sync holds with pin high");

    // R7: clearing the shadow without commit keeps the hold
    cfg_write(1'b0, 1'b0);
    hold_low_and_check(20, "R7 shadow clear no effect");

    // R9: pin low while soft also active keeps it low
    sync_n = 1'b0;
    hold_low_and_check(10, "R9 both sources hold");
    sync_n = 1'b1;
    hold_low_and_check(30, "R9 soft alone still holds");

    // R8: committed soft release restarts 13 edges after the accepting edge
    cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 1'b1;
    @(negedge clk_in);
    cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = 1'b0;
    wait_rise(lat);
    check(lat == SOFT_LAT, "R8 soft release latency", lat, SOFT_LAT);
    measure_period(hi, lo);
    check(hi == 3 && lo == 3, "R8 R4 period after soft release", hi * 10 + lo, 33);

    // R1: reset in the middle of a run returns the output low
    rst_n = 1'b0;
    @(negedge clk_in);
    check(clk_out == 1'b0, "R1 reset mid-run", clk_out, 0);
    rst_n = 1'b1;
    wait_rise(lat);
    check(lat == PIN_LAT, "R1 R3 restart after reset", lat, PIN_LAT);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule